// File: doc/BRIEF.md
# Four-Phase Handshake Relay Stage

This block is a clocked relay that holds a single token between two return-to-zero request/acknowledge channels. A producer offers a word by raising `in_req` with `in_data` valid. The stage captures the word, answers with `in_ack`, and later presents it on `out_data` while raising `out_req`. A downstream consumer completes that transfer by raising `out_ack`. Both handshakes are full four-phase cycles: each side returns its signal to zero before the next token can move.

Inside are a data register and a one-bit occupancy flag. A fixed-priority rule chain decides what happens on each clock, and at most one rule fires per cycle. The first rule is "emit": it fires when the stage is occupied and the output channel is idle. The second rule is "take": it fires when the stage is empty and a fresh input token is waiting. The return-to-zero bookkeeping on both channels runs in the same cycle as the rule chain. Reset is synchronous and active-high. While reset is applied, the input acknowledge is held high, so a request that is already pending is never mistaken for a new token.

Top module: `four_phase_relay`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is `in_ack`=1, `out_req`=0 and `out_data`=0. With the default parameters the stage is also left empty.
- R2: After reset is released with `in_req` low, `in_ack` drops to 0 at the first rising edge.
- R3: A request that is held high through reset and after it is never captured. `in_ack` stays 1 and `out_req` stays 0 until `in_req` returns to 0.
- R4: When the stage is empty, `in_req`=1 and `in_ack`=0 at a rising edge, that edge captures `in_data` and sets `in_ack` to 1.
- R5: When `in_ack`=1 and `in_req`=0 at a rising edge, `in_ack` becomes 0 at that edge.
- R6: When the stage holds a token and `out_req`=0 and `out_ack`=0 at a rising edge, that edge raises `out_req` with the token on `out_data`. Both stay unchanged until `out_ack` is seen high.
- R7: When `out_req`=1 and `out_ack`=1 at a rising edge, `out_req` and `out_data` both become 0 at that edge (default configuration, where the output data is not retained).
- R8: Every accepted token is delivered exactly once, in acceptance order, whatever delays the producer and consumer insert.
- R9: The stage stores at most one token. The count of `in_ack` rises minus the count of `out_req` rises is always 0 or 1, so a new request stays unacknowledged while a captured token waits for the output channel.
- R10: `out_req` only falls after `out_ack` was high, and `in_ack` only falls after `in_req` was low.
- R11: Only one rule fires per cycle: a rise of `in_ack` and a rise of `out_req` never occur at the same edge, and emit takes precedence over take.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_req | input | 1 | Producer request |
| in_data | input | DATA_W | Producer data, valid while `in_req` is high |
| in_ack | output | 1 | Acknowledge to producer (registered) |
| out_req | output | 1 | Request to consumer (registered) |
| out_data | output | DATA_W | Data to consumer (registered) |
| out_ack | input | 1 | Consumer acknowledge |

## Verification
Directed sequences come first, each with cycle-exact checks:
- A clean reset separates the reset state from the first release of the acknowledge.
- A reset with a request already pending shows that a stale request is never captured.
- A single token run with the consumer stalled shows that the output word is held steady.
- A second and third token sent against that stalled consumer show the one-token limit and the priority of emit over take.

After that, a producer and a consumer with random delays stream a long run of tokens through the stage. A scoreboard catches any loss, duplication or reordering, and an edge monitor catches any handshake edge that breaks the four-phase protocol.

// File: rtl/relay_pkg.sv
package relay_pkg;

  // Outcome of the per-cycle rule chain; at most one rule fires.
  typedef enum logic [1:0] {
    RULE_IDLE = 2'd0,
    RULE_EMIT = 2'd1,
    RULE_TAKE = 2'd2
  } rule_e;

endpackage

// File: rtl/relay_in_chan.sv
module relay_in_chan (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic take_i,
  output logic ack_o,
  output logic ready_o
);

  logic ack_q;

  // Reset forces the acknowledge high so a pending request is not a token.
  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q <= 1'b1;
    end else if (ack_q && !req_i) begin
      ack_q <= 1'b0;
    end else if (take_i) begin
      ack_q <= 1'b1;
    end
  end

  assign ack_o   = ack_q;
  assign ready_o = req_i && !ack_q;

  assert_take_legal_R4: assert property (@(posedge clk) disable iff (rst)
    take_i |-> (req_i && !ack_q));

  assert_take_ack_R4: assert property (@(posedge clk) disable iff (rst)
    take_i |=> ack_q);

  assert_ack_release_R5: assert property (@(posedge clk) disable iff (rst)
    (ack_q && !req_i) |=> !ack_q);

  assert_ack_fall_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_q) |-> !$past(req_i));

endmodule

// File: rtl/relay_out_chan.sv
module relay_out_chan #(
  parameter int DATA_W    = 8,
  parameter bit KEEP_DATA = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ack_i,
  input  logic              launch_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              req_o,
  output logic [DATA_W-1:0] data_o,
  output logic              idle_o
);

  logic              req_q;
  logic [DATA_W-1:0] data_q;
  logic              done;

  assign done = req_q && ack_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
    end else if (done) begin
      req_q <= 1'b0;
    end else if (launch_i) begin
      req_q <= 1'b1;
    end
  end

  generate
    if (KEEP_DATA) begin : g_keep
      always_ff @(posedge clk) begin
        if (!rst && !done && launch_i) data_q <= data_i;
      end
    end else begin : g_clear
      always_ff @(posedge clk) begin
        if (rst || done) begin
          data_q <= '0;
        end else if (launch_i) begin
          data_q <= data_i;
        end
      end

      assert_data_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (req_q && ack_i) |=> (data_q == '0));
    end
  endgenerate

  assign req_o  = req_q;
  assign data_o = data_q;
  assign idle_o = !req_q && !ack_i;

  assert_launch_legal_R6: assert property (@(posedge clk) disable iff (rst)
    launch_i |-> (!req_q && !ack_i));

  assert_launch_data_R6: assert property (@(posedge clk) disable iff (rst)
    launch_i |=> (req_q && data_q == $past(data_i)));

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (req_q && !ack_i) |=> (req_q && $stable(data_q)));

  assert_req_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (req_q && ack_i) |=> !req_q);

  assert_req_fall_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(req_q) |-> $past(ack_i));

endmodule

// File: rtl/relay_rules.sv
module relay_rules
  import relay_pkg::*;
(
  input  logic  full_i,
  input  logic  out_idle_i,
  input  logic  in_ready_i,
  output rule_e rule_o
);

  // Strict priority chain: the first rule whose triggers all hold wins.
  always_comb begin
    if (full_i && out_idle_i) begin
      rule_o = RULE_EMIT;
    end else if (!full_i && in_ready_i) begin
      rule_o = RULE_TAKE;
    end else begin
      rule_o = RULE_IDLE;
    end
  end

endmodule

// File: rtl/four_phase_relay.sv
module four_phase_relay
  import relay_pkg::*;
#(
  parameter int              DATA_W    = 8,
  parameter bit              INIT_FULL = 1'b0,
  parameter logic [DATA_W-1:0] INIT_DATA = '0,
  parameter bit              KEEP_DATA = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_req,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ack,
  output logic              out_req,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ack
);

  logic              full_q;
  logic [DATA_W-1:0] hold_q;
  logic              in_ready;
  logic              out_idle;
  rule_e             rule;
  logic              do_take;
  logic              do_emit;

  relay_in_chan u_in (
    .clk     (clk),
    .rst     (rst),
    .req_i   (in_req),
    .take_i  (do_take),
    .ack_o   (in_ack),
    .ready_o (in_ready)
  );

  relay_rules u_rules (
    .full_i     (full_q),
    .out_idle_i (out_idle),
    .in_ready_i (in_ready),
    .rule_o     (rule)
  );

  assign do_take = (rule == RULE_TAKE);
  assign do_emit = (rule == RULE_EMIT);

  relay_out_chan #(
    .DATA_W    (DATA_W),
    .KEEP_DATA (KEEP_DATA)
  ) u_out (
    .clk      (clk),
    .rst      (rst),
    .ack_i    (out_ack),
    .launch_i (do_emit),
    .data_i   (hold_q),
    .req_o    (out_req),
    .data_o   (out_data),
    .idle_o   (out_idle)
  );

  // Token storage: the occupancy flag is filled by take and drained by emit.
  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= INIT_FULL;
      hold_q <= INIT_DATA;
    end else begin
      unique case (rule)
        RULE_EMIT: full_q <= 1'b0;
        RULE_TAKE: begin
          full_q <= 1'b1;
          hold_q <= in_data;
        end
        default: ;
      endcase
    end
  end

  // Port-level occupancy tracking for the capacity check.
  logic       ack_d;
  logic       req_d;
  logic [1:0] bal_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_d <= 1'b1;
      req_d <= 1'b0;
      bal_q <= 2'(INIT_FULL);
    end else begin
      ack_d <= in_ack;
      req_d <= out_req;
      bal_q <= bal_q + 2'(in_ack && !ack_d) - 2'(out_req && !req_d);
    end
  end

  assert_capacity_R9: assert property (@(posedge clk) disable iff (rst)
    bal_q <= 2'd1);

  assert_single_rule_R11: assert property (@(posedge clk) disable iff (rst)
    !($rose(in_ack) && $rose(out_req)));

  assert_full_blocks_take_R9: assert property (@(posedge clk) disable iff (rst)
    (full_q && in_ready) |=> !$rose(in_ack));

endmodule

// File: tb/test_four_phase_relay.sv
module test_four_phase_relay;

  localparam int DW    = 8;
  localparam int NSTR  = 60;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_req = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ack;
  logic          out_req;
  logic [DW-1:0] out_data;
  logic          out_ack = 1'b0;

  int n_chk  = 0;
  int n_fail = 0;
  int viol   = 0;
  logic [DW-1:0] expq[$];

  always #10 clk = ~clk;

  four_phase_relay #(.DATA_W(DW)) i_four_phase_relay (
    .clk      (clk),
    .rst      (rst),
    .in_req   (in_req),
    .in_data  (in_data),
    .in_ack   (in_ack),
    .out_req  (out_req),
    .out_data (out_data),
    .out_ack  (out_ack)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Protocol edge monitor (R10, R11)
  logic p_req, p_ack, p_in_req, p_out_ack, p_valid;
  logic [DW-1:0] p_data;
  always @(negedge clk) begin
    if (rst) begin
      p_valid <= 1'b0;
    end else begin
      if (p_valid) begin
        if (p_req && !out_req && !p_out_ack) viol++;
        if (p_ack && !in_ack && p_in_req) viol++;
        if (p_req && out_req && out_data != p_data) viol++;
        if (!p_req && out_req && !p_ack && in_ack) viol++;
      end
      p_valid   <= 1'b1;
      p_req     <= out_req;
      p_ack     <= in_ack;
      p_in_req  <= in_req;
      p_out_ack <= out_ack;
      p_data    <= out_data;
    end
  end

  task automatic produce(input int n);
    for (int i = 0; i < n; i++) begin
      repeat ($urandom_range(0, 3)) tick();
      in_data = DW'(i * 37 + 11);
      expq.push_back(in_data);
      in_req = 1'b1;
      while (!in_ack) tick();
      repeat ($urandom_range(0, 2)) tick();
      in_req = 1'b0;
      while (in_ack) tick();
    end
  endtask

  task automatic consume(input int n);
    for (int i = 0; i < n; i++) begin
      logic [DW-1:0] e;
      while (!out_req) tick();
      repeat ($urandom_range(0, 3)) tick();
      if (expq.size() == 0) begin
        chk(1'b0, "R8", "token without expectation", int'(out_data), -1);
      end else begin
        e = expq.pop_front();
        chk(out_data == e, "R8", "streamed token", int'(out_data), int'(e));
      end
      out_ack = 1'b1;
      while (out_req) tick();
      repeat ($urandom_range(0, 2)) tick();
      out_ack = 1'b0;
    end
  endtask

  task automatic run_all();
    // R1: reset state
    repeat (3) tick();
    chk(in_ack == 1'b1, "R1", "in_ack in reset", int'(in_ack), 1);
    chk(out_req == 1'b0, "R1", "out_req in reset", int'(out_req), 0);
    chk(out_data == '0, "R1", "out_data in reset", int'(out_data), 0);
    rst = 1'b0;
    tick();
    chk(in_ack == 1'b0, "R2", "in_ack after release", int'(in_ack), 0);

    // R3: request pending across reset
    rst = 1'b1; in_req = 1'b1; in_data = 8'hAA;
    repeat (2) tick();
    rst = 1'b0;
    for (int k = 0; k < 4; k++) begin
      tick();
      chk(in_ack == 1'b1, "R3", "stale request ack held", int'(in_ack), 1);
      chk(out_req == 1'b0, "R3", "stale request not emitted", int'(out_req), 0);
    end
    in_req = 1'b0;
    tick();
    chk(in_ack == 1'b0, "R5", "ack release after stale", int'(in_ack), 0);

    // Token A, consumer stalled
    in_data = 8'h5A; in_req = 1'b1;
    tick();
    chk(in_ack == 1'b1, "R4", "capture ack", int'(in_ack), 1);
    chk(out_req == 1'b0, "R11", "no emit in take cycle", int'(out_req), 0);
    in_req = 1'b0;
    tick();
    chk(out_req == 1'b1, "R6", "emit request", int'(out_req), 1);
    chk(out_data == 8'h5A, "R6", "emit data", int'(out_data), 8'h5A);
    chk(in_ack == 1'b0, "R5", "ack returns to zero", int'(in_ack), 0);

    // Token B accepted while A waits
    in_data = 8'hB3; in_req = 1'b1;
    tick();
    chk(in_ack == 1'b1, "R4", "second capture", int'(in_ack), 1);
    in_req = 1'b0;
    tick();
    chk(in_ack == 1'b0, "R5", "second ack release", int'(in_ack), 0);

    // Token C must wait: stage already holds B
    in_data = 8'hC7; in_req = 1'b1;
    for (int k = 0; k < 4; k++) begin
      tick();
      chk(in_ack == 1'b0, "R9", "no capture while full", int'(in_ack), 0);
      chk(out_req == 1'b1 && out_data == 8'h5A, "R6", "output held",
          int'(out_data), 8'h5A);
    end

    out_ack = 1'b1;
    tick();
    chk(out_req == 1'b0, "R7", "request drop", int'(out_req), 0);
    chk(out_data == '0, "R7", "data cleared", int'(out_data), 0);
    out_ack = 1'b0;
    tick();
    chk(out_req == 1'b1 && out_data == 8'hB3, "R11", "emit B before take C",
        int'(out_data), 8'hB3);
    chk(in_ack == 1'b0, "R11", "C not taken with emit", int'(in_ack), 0);
    tick();
    chk(in_ack == 1'b1, "R4", "C captured after emit", int'(in_ack), 1);
    in_req = 1'b0;
    out_ack = 1'b1;
    tick();
    chk(out_req == 1'b0, "R7", "B drop", int'(out_req), 0);
    out_ack = 1'b0;
    tick();
    chk(out_req == 1'b1 && out_data == 8'hC7, "R8", "C delivered",
        int'(out_data), 8'hC7);
    out_ack = 1'b1;
    tick();
    out_ack = 1'b0;
    tick();

    // Random streaming
    fork
      produce(NSTR);
      consume(NSTR);
    join
    repeat (4) tick();
    chk(expq.size() == 0, "R8", "all tokens delivered", expq.size(), 0);
    chk(out_req == 1'b0, "R8", "no extra emission", int'(out_req), 0);
    chk(viol == 0, "R10", "handshake edge violations", viol, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R8", "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule